// File: doc/BRIEF.md
# Asymmetric Load Hit Predictor

This block is a single, global confidence counter that tells an instruction scheduler whether the next load should be treated as a first-level cache hit. When it predicts a hit, the scheduler may wake the load's consumers early. When it predicts a miss, the consumers wait until the load's data is really available.

Resolved loads report their outcome on two pulse inputs, `hit_i` and `miss_i`. The counter is biased against speculation. A miss costs twice as much as a hit earns, so a burst of misses quickly turns speculation off. A long run of hits is needed to turn it back on. Only the counter's top bit forms the prediction. The prediction is held in a register, so it reflects the counter as updated at the previous clock edge.

A force-miss input makes the output report a miss unconditionally, which models a fully conservative scheduler. While it is asserted, the counter still learns from every outcome.

Top module: `lhp_predictor`

## Requirements
- R1: A synchronous active-high reset loads the counter with 8. While `rst` is high, and in the first cycle after it falls, `predict_hit_o` reads 1.
- R2: A cycle with `miss_i`=1 and `hit_i`=0 lowers the counter by 2.
- R3: A cycle with `hit_i`=1 and `miss_i`=0 raises the counter by 1.
- R4: The counter saturates at 15. A hit at 15 leaves it at 15 and never wraps to a low value.
- R5: The counter saturates at 0. A miss at 1 or at 0 leaves it at 0 and never wraps to a high value.
- R6: A cycle with both `hit_i` and `miss_i` high changes the counter by -1, and saturation at 0 still applies.
- R7: `predict_hit_o` is a register. After each clock edge it equals bit 3 of the updated counter (1 means hit, for counter values 8 to 15), unless force-miss was sampled high at that edge.
- R8: When `force_miss_i` is sampled high, `predict_hit_o` reads 0 after that edge. The counter keeps updating from `hit_i` and `miss_i` during that time.
- R9: A cycle with neither outcome input high leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| force_miss_i | input | 1 | Forces a miss prediction; training continues |
| hit_i | input | 1 | A resolved load hit the first-level cache |
| miss_i | input | 1 | A resolved load missed the first-level cache |
| predict_hit_o | output | 1 | Registered prediction: 1 = treat the next load as a hit |

## Verification
The bench builds the block with its default parameters:
- a 4-bit counter,
- a hit step of 1,
- a miss step of 2,
- a reset value of 8.

With these values the hit/miss threshold sits only one or two outcomes away from reset. Both saturation rails can be reached within about a dozen cycles, so directed sequences can drive the counter to 15 and to 0 and prove the absence of wraparound by how many opposite steps are then needed to cross the threshold. Long random streams, with force-miss toggled, are compared every clock against a behavioural integer model.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10,
    STEP_NET  = 2'b11
  } step_kind_e;

endpackage

// File: rtl/lhp_step_dec.sv
module lhp_step_dec
  import lhp_pkg::*;
#(
  parameter int HIT_STEP  = 1,
  parameter int MISS_STEP = 2,
  parameter int DW        = 6
) (
  input  logic                 hit_i,
  input  logic                 miss_i,
  output step_kind_e           kind_o,
  output logic signed [DW-1:0] delta_o
);

  localparam logic signed [DW-1:0] UP_D   = DW'(HIT_STEP);
  localparam logic signed [DW-1:0] DOWN_D = -DW'(MISS_STEP);
  localparam logic signed [DW-1:0] NET_D  = DW'(HIT_STEP - MISS_STEP);

  always_comb begin
    kind_o = step_kind_e'({miss_i, hit_i});
    unique case (kind_o)
      STEP_UP:   delta_o = UP_D;
      STEP_DOWN: delta_o = DOWN_D;
      STEP_NET:  delta_o = NET_D;
      default:   delta_o = '0;
    endcase
  end

endmodule

// File: rtl/lhp_sat_cnt.sv
module lhp_sat_cnt #(
  parameter int CNT_W     = 4,
  parameter int DW        = 6,
  parameter int RESET_VAL = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] delta_i,
  output logic [CNT_W-1:0]     count_q,
  output logic [CNT_W-1:0]     count_d
);

  localparam logic [CNT_W-1:0]     MAX_V = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]     RST_V = CNT_W'(RESET_VAL);
  localparam logic signed [DW-1:0] MAX_S = $signed({{(DW-CNT_W){1'b0}}, MAX_V});

  logic signed [DW-1:0] sum;

  always_comb begin
    sum = $signed({{(DW-CNT_W){1'b0}}, count_q}) + delta_i;
    if (sum < 0)
      count_d = '0;
    else if (sum > MAX_S)
      count_d = MAX_V;
    else
      count_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= RST_V;
    else     count_q <= count_d;
  end

endmodule

// File: rtl/lhp_out_reg.sv
module lhp_out_reg #(
  parameter int CNT_W     = 4,
  parameter int RESET_VAL = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             force_miss_i,
  input  logic [CNT_W-1:0] count_d,
  output logic             predict_q
);

  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RESET_VAL);

  always_ff @(posedge clk) begin
    if (rst) predict_q <= RST_V[CNT_W-1];
    else     predict_q <= !force_miss_i && count_d[CNT_W-1];
  end

endmodule

// File: rtl/lhp_predictor.sv
module lhp_predictor
  import lhp_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int HIT_STEP  = 1,
  parameter int MISS_STEP = 2,
  parameter int RESET_VAL = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic force_miss_i,
  input  logic hit_i,
  input  logic miss_i,
  output logic predict_hit_o
);

  localparam int DW = CNT_W + 2;

  step_kind_e           step_kind;
  logic signed [DW-1:0] step_delta;
  logic [CNT_W-1:0]     count_q;
  logic [CNT_W-1:0]     count_d;

  lhp_step_dec #(
    .HIT_STEP (HIT_STEP),
    .MISS_STEP(MISS_STEP),
    .DW       (DW)
  ) u_dec (
    .hit_i  (hit_i),
    .miss_i (miss_i),
    .kind_o (step_kind),
    .delta_o(step_delta)
  );

  lhp_sat_cnt #(
    .CNT_W    (CNT_W),
    .DW       (DW),
    .RESET_VAL(RESET_VAL)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .delta_i(step_delta),
    .count_q(count_q),
    .count_d(count_d)
  );

  lhp_out_reg #(
    .CNT_W    (CNT_W),
    .RESET_VAL(RESET_VAL)
  ) u_out (
    .clk         (clk),
    .rst         (rst),
    .force_miss_i(force_miss_i),
    .count_d     (count_d),
    .predict_q   (predict_hit_o)
  );

endmodule

// File: rtl/lhp_predictor_chk.sv
module lhp_predictor_chk #(
  parameter int CNT_W     = 4,
  parameter int HIT_STEP  = 1,
  parameter int MISS_STEP = 2,
  parameter int RESET_VAL = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             force_miss_i,
  input logic             hit_i,
  input logic             miss_i,
  input logic             predict_hit_o,
  input logic [CNT_W-1:0] cnt
);

  localparam int MAXI = (1 << CNT_W) - 1;

  assert_reset_load_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (int'(cnt) == RESET_VAL) && predict_hit_o);

  assert_miss_step_R2: assert property (@(posedge clk) disable iff (rst)
    (miss_i && !hit_i && int'(cnt) >= MISS_STEP) |=> int'(cnt) == int'($past(cnt)) - MISS_STEP);

  assert_hit_step_R3: assert property (@(posedge clk) disable iff (rst)
    (hit_i && !miss_i && int'(cnt) + HIT_STEP <= MAXI) |=> int'(cnt) == int'($past(cnt)) + HIT_STEP);

  assert_top_rail_R4: assert property (@(posedge clk) disable iff (rst)
    (hit_i && !miss_i && int'(cnt) == MAXI) |=> int'(cnt) == MAXI);

  assert_bottom_rail_R5: assert property (@(posedge clk) disable iff (rst)
    (miss_i && !hit_i && int'(cnt) < MISS_STEP) |=> cnt == '0);

  assert_net_step_R6: assert property (@(posedge clk) disable iff (rst)
    (hit_i && miss_i && int'(cnt) >= 1) |=> int'(cnt) == int'($past(cnt)) - 1);

  assert_out_msb_R7: assert property (@(posedge clk) disable iff (rst)
    !force_miss_i |=> predict_hit_o == cnt[CNT_W-1]);

  assert_force_off_R8: assert property (@(posedge clk) disable iff (rst)
    force_miss_i |=> !predict_hit_o);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!hit_i && !miss_i) |=> $stable(cnt));

endmodule

bind lhp_predictor lhp_predictor_chk #(
  .CNT_W    (CNT_W),
  .HIT_STEP (HIT_STEP),
  .MISS_STEP(MISS_STEP),
  .RESET_VAL(RESET_VAL)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .force_miss_i (force_miss_i),
  .hit_i        (hit_i),
  .miss_i       (miss_i),
  .predict_hit_o(predict_hit_o),
  .cnt          (count_q)
);

// File: tb/lhp_predictor_bench.sv
module lhp_predictor_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic force_miss_i = 1'b0;
  logic hit_i = 1'b0;
  logic miss_i = 1'b0;
  logic predict_hit_o;

  int checks = 0;
  int failures = 0;
  int mcnt = 8;
  bit mpred = 1'b1;

  always #5 clk = ~clk;

  lhp_predictor u_lhp_predictor (
    .clk          (clk),
    .rst          (rst),
    .force_miss_i (force_miss_i),
    .hit_i        (hit_i),
    .miss_i       (miss_i),
    .predict_hit_o(predict_hit_o)
  );

  task automatic check(input bit exp, input string req);
    checks++;
    if (predict_hit_o !== exp) begin
      failures++;
      $display("FAIL %s: predict_hit_o=%b expected=%b (t=%0t)", req, predict_hit_o, exp, $time);
    end
  endtask

  // Apply one cycle of stimulus, update the model at the edge, sample after it.
  task automatic step(input bit h, input bit m, input bit f);
    hit_i = h; miss_i = m; force_miss_i = f;
    @(posedge clk);
    if (rst) mcnt = 8;
    else begin
      mcnt = mcnt + (h ? 1 : 0) - (m ? 2 : 0);
      if (mcnt < 0)  mcnt = 0;
      if (mcnt > 15) mcnt = 15;
    end
    mpred = rst ? 1'b1 : (!f && mcnt >= 8);
    #2;
  endtask

  task automatic run(input bit h, input bit m, input bit f, input int n, input bit exp, input string req);
    for (int i = 0; i < n; i++) step(h, m, f);
    check(exp, req);
    check(mpred, req);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    step(0, 0, 0); step(1, 0, 1); step(0, 1, 0);
    check(1'b1, "R1 during reset");
    rst = 1'b0;
    step(0, 0, 0);
    check(1'b1, "R1 after reset");   // counter 8

    run(0, 1, 0, 1, 1'b0, "R2 miss 8->6");
    run(1, 0, 0, 1, 1'b0, "R3 hit 6->7");
    run(1, 0, 0, 1, 1'b1, "R3 hit 7->8");
    run(1, 1, 0, 1, 1'b0, "R6 both 8->7");
    run(1, 0, 0, 1, 1'b1, "R3 hit 7->8");
    run(0, 0, 0, 3, 1'b1, "R9 idle holds 8");
    run(0, 0, 0, 1, 1'b1, "R7 output follows counter msb");
    run(1, 0, 1, 7, 1'b0, "R8 forced off while training to 15");
    run(0, 0, 0, 1, 1'b1, "R8 training continued under force");
    run(1, 0, 0, 5, 1'b1, "R4 hits at 15");
    run(0, 1, 0, 3, 1'b1, "R4 no wrap: 15->9");
    run(0, 1, 0, 1, 1'b0, "R4 no wrap: 9->7");
    run(0, 1, 0, 6, 1'b0, "R5 misses down to 0");
    run(1, 1, 0, 1, 1'b0, "R6 both at 0 saturates");
    run(1, 0, 0, 7, 1'b0, "R5 no wrap: 0->7");
    run(1, 0, 0, 1, 1'b1, "R5 no wrap: 7->8");

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 55, (r % 3) == 0, $urandom_range(0, 9) == 0);
      check(mpred, "R7 random stream vs model");
    end

    rst = 1'b1;
    step(1, 1, 1);
    rst = 1'b0;
    step(0, 0, 0);
    check(1'b1, "R1 mid-run reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule